// File: doc/BRIEF.md
# Load-Adaptive PWM Timing Generator

This block generates the switching cycles for a flyback controller that regulates from the primary side. It receives two digitized control codes. One is a load indicator from the voltage loop. The other is an error code from the current loop. The smaller code is the control value that sets the on-time. The load indicator alone sets the switching period.

At heavy load the period sits at its nominal value and follows a slow triangular dither that spreads conducted emissions. As the load indicator falls below a knee, the period stretches linearly. It reaches a long fixed ceiling when the indicator sits at or below a floor code. Within each period, the gate pulse starts at count zero. It ends at the first of these events:
- the control compare (never before a minimum on-time),
- a maximum-duty count,
- an external current-limit flag, which is ignored during a leading-edge blanking window,
- an external ramp-compare flag.

Protection logic gates the output through an enable input. The analog sensing, the slope ramp and the output driver live outside this block. With the default 100 MHz clock, the default parameters give a 50 kHz nominal rate, a dither band of about 46 to 54 kHz, and a 370 Hz floor.

Top module: `lapwm_top`

## Requirements
- R1: While reset is active the gate output is low; after reset the first pulse starts at the first period start.
- R2: The control value is the smaller of the load code and the current-error code; with no flag active, the pulse width in cycles is max(MIN_ON_CYC, floor(ctrl*P/2^CODE_W)), limited by R7, where P is that period's length.
- R3: When the load code is at or above KNEE_CODE, every period lies in [NOM_PERIOD-HOP_DEV, NOM_PERIOD+HOP_DEV].
- R4: At heavy load, consecutive periods differ by exactly one cycle, and the triangular sweep reaches both band edges.
- R5: When FLOOR_CODE < load code < KNEE_CODE, the period is NOM_PERIOD+(KNEE_CODE-code)*SLOPE, capped at MAX_PERIOD, with no dither; SLOPE=(MAX_PERIOD-NOM_PERIOD)/(KNEE_CODE-FLOOR_CODE) using integer division.
- R6: When the load code is at or below FLOOR_CODE, the period equals MAX_PERIOD.
- R7: The pulse width never exceeds floor(P*DUTY_NUM/256).
- R8: A pulse that only the control compare ends is never shorter than MIN_ON_CYC cycles.
- R9: If the current-limit flag is high in the cycle where the in-period count c is at least BLANK_CYC, the gate is low from the next cycle for the rest of the period, giving width c+1.
- R10: The current-limit flag has no effect while the count is below BLANK_CYC. A flag held high throughout therefore gives width BLANK_CYC+1.
- R11: The ramp-compare flag ends the pulse as in R9, but not before MIN_ON_CYC cycles. A flag held high gives width max(BLANK_CYC+1, MIN_ON_CYC).
- R12: A low enable forces the gate low in the same cycle. After enable returns high, the gate stays low until the next period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| load_code_i | input | CODE_W | Load indicator from the voltage loop; sets the period and is one control candidate |
| ierr_code_i | input | CODE_W | Current-loop error code; the other control candidate |
| ilim_trip_i | input | 1 | Current-limit comparator flag |
| ramp_trip_i | input | 1 | Sensed-current-plus-ramp comparator flag |
| drive_en_i | input | 1 | Enable from the protection logic |
| gate_o | output | 1 | Gate command |

## Verification
The load code is swept across the deep floor, the floor boundary, the linear stretch region and the knee. This separates the ceiling clamp from the linear formula and from the dithered band. At a fixed stretched period, the error code is stepped through the whole code range both below and above the load code. This shows that the smaller code is taken, and it shows where the minimum on-time and the maximum-duty cap take over from the linear compare. Both flags are applied once held high and once raised mid-pulse. The held flag exposes the blanking window and the different minimum for each flag. The mid-pulse flag exposes the exact cut-off cycle. A mid-period enable drop and re-raise shows the immediate shut-off and the wait for the next period start.

// File: rtl/lapwm_pkg.sv
package lapwm_pkg;

   // Direction of the period dither sweep.
   typedef enum logic {
      SWEEP_DN = 1'b0,
      SWEEP_UP = 1'b1
   } sweep_dir_e;

   // Duty fractions are expressed in 1/256 units.
   localparam int DUTY_SHIFT = 8;

endpackage

// File: rtl/lapwm_hop.sv
module lapwm_hop
   import lapwm_pkg::*;
#(
   parameter int HOP_DEV = 160,
   parameter int OFS_W   = $clog2(2*HOP_DEV+1)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             step_i,
   output logic [OFS_W-1:0] ofs_o
);

   // Biased offset: 0 is the lowest period, 2*HOP_DEV the highest.
   localparam logic [OFS_W-1:0] OFS_TOP = OFS_W'(2*HOP_DEV);
   localparam logic [OFS_W-1:0] OFS_MID = OFS_W'(HOP_DEV);

   logic [OFS_W-1:0] ofs_q;
   sweep_dir_e       dir_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         ofs_q <= OFS_MID;
         dir_q <= SWEEP_UP;
      end else if (step_i) begin
         if (dir_q == SWEEP_UP) begin
            if (ofs_q == OFS_TOP) begin
               ofs_q <= ofs_q - 1'b1;
               dir_q <= SWEEP_DN;
            end else begin
               ofs_q <= ofs_q + 1'b1;
            end
         end else begin
            if (ofs_q == '0) begin
               ofs_q <= ofs_q + 1'b1;
               dir_q <= SWEEP_UP;
            end else begin
               ofs_q <= ofs_q - 1'b1;
            end
         end
      end
   end

   assign ofs_o = ofs_q;

endmodule

// File: rtl/lapwm_period.sv
module lapwm_period
   import lapwm_pkg::*;
#(
   parameter int CODE_W     = 8,
   parameter int PER_W      = 19,
   parameter int OFS_W      = 9,
   parameter int NOM_PERIOD = 2000,
   parameter int HOP_DEV    = 160,
   parameter int MAX_PERIOD = 270270,
   parameter int KNEE_CODE  = 128,
   parameter int FLOOR_CODE = 16,
   parameter int DUTY_NUM   = 166
) (
   input  logic [CODE_W-1:0] load_code_i,
   input  logic [CODE_W-1:0] ierr_code_i,
   input  logic [OFS_W-1:0]  ofs_i,
   output logic [PER_W-1:0]  per_o,
   output logic [PER_W-1:0]  ontgt_o,
   output logic [PER_W-1:0]  maxon_o
);

   localparam int SLOPE   = (MAX_PERIOD - NOM_PERIOD) / (KNEE_CODE - FLOOR_CODE);
   localparam int PROD_W  = CODE_W + PER_W;
   localparam int DPROD_W = PER_W + DUTY_SHIFT;

   logic [CODE_W-1:0]  ctrl;
   logic               heavy, deep;
   logic [CODE_W-1:0]  gap;
   logic [PROD_W-1:0]  stretch;
   logic [PROD_W-1:0]  on_prod;
   logic [DPROD_W-1:0] duty_prod;

   always_comb begin
      ctrl    = (load_code_i < ierr_code_i) ? load_code_i : ierr_code_i;
      heavy   = load_code_i >= CODE_W'(KNEE_CODE);
      deep    = load_code_i <= CODE_W'(FLOOR_CODE);
      gap     = CODE_W'(KNEE_CODE) - load_code_i;
      stretch = PROD_W'(NOM_PERIOD) + PROD_W'(gap) * PROD_W'(SLOPE);

      if (heavy)
         per_o = PER_W'(NOM_PERIOD - HOP_DEV) + PER_W'(ofs_i);
      else if (deep || stretch > PROD_W'(MAX_PERIOD))
         per_o = PER_W'(MAX_PERIOD);
      else
         per_o = stretch[PER_W-1:0];

      on_prod   = PROD_W'(ctrl) * PROD_W'(per_o);
      ontgt_o   = on_prod[PROD_W-1:CODE_W];
      duty_prod = DPROD_W'(per_o) * DPROD_W'(DUTY_NUM);
      maxon_o   = duty_prod[DPROD_W-1:DUTY_SHIFT];
   end

endmodule

// File: rtl/lapwm_pulse.sv
module lapwm_pulse #(
   parameter int PER_W      = 19,
   parameter int NOM_PERIOD = 2000,
   parameter int BLANK_CYC  = 30,
   parameter int MIN_ON_CYC = 80
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic             ilim_i,
   input  logic             ramp_i,
   input  logic [PER_W-1:0] per_i,
   input  logic [PER_W-1:0] ontgt_i,
   input  logic [PER_W-1:0] maxon_i,
   output logic             wrap_o,
   output logic             gate_o,
   output logic [PER_W-1:0] cnt_o,
   output logic [PER_W-1:0] per_o,
   output logic [PER_W-1:0] maxon_o
);

   logic [PER_W-1:0] cnt_q, per_q, ontgt_q, maxon_q;
   logic             gate_q;
   logic [PER_W-1:0] cnt_nx;
   logic             past_blank, past_min, stop;

   always_comb begin
      cnt_nx     = cnt_q + 1'b1;
      wrap_o     = (cnt_q == per_q - 1'b1);
      past_blank = cnt_q >= PER_W'(BLANK_CYC);
      past_min   = cnt_nx >= PER_W'(MIN_ON_CYC);
      stop       = (cnt_nx >= maxon_q)
                 | ((cnt_nx >= ontgt_q) & past_min)
                 | (ilim_i & past_blank)
                 | (ramp_i & past_blank & past_min);
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         cnt_q   <= PER_W'(NOM_PERIOD - 1);
         per_q   <= PER_W'(NOM_PERIOD);
         ontgt_q <= '0;
         maxon_q <= '0;
         gate_q  <= 1'b0;
      end else if (wrap_o) begin
         cnt_q   <= '0;
         per_q   <= per_i;
         ontgt_q <= ontgt_i;
         maxon_q <= maxon_i;
         gate_q  <= en_i;
      end else begin
         cnt_q   <= cnt_nx;
         gate_q  <= gate_q & en_i & ~stop;
      end
   end

   assign gate_o  = gate_q & en_i;
   assign cnt_o   = cnt_q;
   assign per_o   = per_q;
   assign maxon_o = maxon_q;

endmodule

// File: rtl/lapwm_top.sv
module lapwm_top #(
   parameter int CODE_W     = 8,
   parameter int NOM_PERIOD = 2000,
   parameter int HOP_DEV    = 160,
   parameter int HOP_EN     = 1,
   parameter int MAX_PERIOD = 270270,
   parameter int KNEE_CODE  = 128,
   parameter int FLOOR_CODE = 16,
   parameter int DUTY_NUM   = 166,
   parameter int BLANK_CYC  = 30,
   parameter int MIN_ON_CYC = 80
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [CODE_W-1:0] load_code_i,
   input  logic [CODE_W-1:0] ierr_code_i,
   input  logic              ilim_trip_i,
   input  logic              ramp_trip_i,
   input  logic              drive_en_i,
   output logic              gate_o
);

   localparam int PER_W = $clog2(MAX_PERIOD + 1);
   localparam int OFS_W = $clog2(2*HOP_DEV + 1);

   if (NOM_PERIOD <= HOP_DEV)
      $error("lapwm_top: NOM_PERIOD must exceed HOP_DEV");
   if (NOM_PERIOD + HOP_DEV > MAX_PERIOD)
      $error("lapwm_top: dither band exceeds MAX_PERIOD");
   if (KNEE_CODE <= FLOOR_CODE || KNEE_CODE >= (1 << CODE_W))
      $error("lapwm_top: bad knee or floor code");
   if (DUTY_NUM < 1 || DUTY_NUM > 255)
      $error("lapwm_top: DUTY_NUM out of range");
   if (((NOM_PERIOD - HOP_DEV) * DUTY_NUM) / 256 < 1)
      $error("lapwm_top: duty cap rounds to zero");

   logic [OFS_W-1:0] hop_ofs;
   logic [PER_W-1:0] per_nx, ontgt_nx, maxon_nx;
   logic             wrap;
   logic [PER_W-1:0] dbg_cnt, dbg_per, dbg_maxon;

   if (HOP_EN != 0) begin : g_hop
      lapwm_hop #(.HOP_DEV(HOP_DEV), .OFS_W(OFS_W)) u_hop (
         .clk_i  (clk_i),
         .rst_i  (rst_i),
         .step_i (wrap),
         .ofs_o  (hop_ofs)
      );
   end else begin : g_fixed
      assign hop_ofs = OFS_W'(HOP_DEV);
   end

   lapwm_period #(
      .CODE_W(CODE_W), .PER_W(PER_W), .OFS_W(OFS_W),
      .NOM_PERIOD(NOM_PERIOD), .HOP_DEV(HOP_DEV), .MAX_PERIOD(MAX_PERIOD),
      .KNEE_CODE(KNEE_CODE), .FLOOR_CODE(FLOOR_CODE), .DUTY_NUM(DUTY_NUM)
   ) u_period (
      .load_code_i (load_code_i),
      .ierr_code_i (ierr_code_i),
      .ofs_i       (hop_ofs),
      .per_o       (per_nx),
      .ontgt_o     (ontgt_nx),
      .maxon_o     (maxon_nx)
   );

   lapwm_pulse #(
      .PER_W(PER_W), .NOM_PERIOD(NOM_PERIOD),
      .BLANK_CYC(BLANK_CYC), .MIN_ON_CYC(MIN_ON_CYC)
   ) u_pulse (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .en_i    (drive_en_i),
      .ilim_i  (ilim_trip_i),
      .ramp_i  (ramp_trip_i),
      .per_i   (per_nx),
      .ontgt_i (ontgt_nx),
      .maxon_i (maxon_nx),
      .wrap_o  (wrap),
      .gate_o  (gate_o),
      .cnt_o   (dbg_cnt),
      .per_o   (dbg_per),
      .maxon_o (dbg_maxon)
   );

endmodule

// File: rtl/lapwm_chk.sv
module lapwm_chk #(
   parameter int PER_W      = 19,
   parameter int NOM_PERIOD = 2000,
   parameter int HOP_DEV    = 160,
   parameter int MAX_PERIOD = 270270,
   parameter int BLANK_CYC  = 30
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             en_i,
   input logic             ilim_i,
   input logic             gate_i,
   input logic [PER_W-1:0] cnt_i,
   input logic [PER_W-1:0] per_i,
   input logic [PER_W-1:0] maxon_i
);

   p_rst_quiet_r1: assert property (@(posedge clk_i) rst_i |-> !gate_i);

   p_disabled_quiet_r12: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |-> !gate_i);

   p_rise_at_start_r12: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(gate_i) |-> (cnt_i == '0));

   p_duty_cap_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      gate_i |-> (cnt_i < maxon_i));

   p_ilim_cut_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (gate_i && ilim_i && cnt_i >= PER_W'(BLANK_CYC) && cnt_i != per_i - 1'b1)
      |=> !gate_i);

   p_period_band_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (per_i >= PER_W'(NOM_PERIOD - HOP_DEV)) && (per_i <= PER_W'(MAX_PERIOD)));

endmodule

bind lapwm_top lapwm_chk #(
   .PER_W(PER_W), .NOM_PERIOD(NOM_PERIOD), .HOP_DEV(HOP_DEV),
   .MAX_PERIOD(MAX_PERIOD), .BLANK_CYC(BLANK_CYC)
) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .en_i    (drive_en_i),
   .ilim_i  (ilim_trip_i),
   .gate_i  (gate_o),
   .cnt_i   (dbg_cnt),
   .per_i   (dbg_per),
   .maxon_i (dbg_maxon)
);

// File: tb/lapwm_top_tb_top.sv
module lapwm_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NOM = 40, DEV = 3, MAXP = 264, KNEE = 128, FLR = 16;
   localparam int DUTY = 166, BLANK = 4, MINON = 6;
   localparam int SLOPE = (MAXP - NOM) / (KNEE - FLR);
   localparam int WATCHDOG = 190000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] vcode = 8'd200;
   logic [7:0] icode = 8'd255;
   logic       ilim = 1'b0, ramp = 1'b0, en = 1'b1;
   logic       gate;

   int total = 0, bad = 0;
   bit done = 1'b0;
   int per_a[20];
   int wid_a[20];

   always #(CLK_PERIOD/2) clk = ~clk;

   lapwm_top #(
      .CODE_W(8), .NOM_PERIOD(NOM), .HOP_DEV(DEV), .HOP_EN(1),
      .MAX_PERIOD(MAXP), .KNEE_CODE(KNEE), .FLOOR_CODE(FLR),
      .DUTY_NUM(DUTY), .BLANK_CYC(BLANK), .MIN_ON_CYC(MINON)
   ) dut_i (
      .clk_i(clk), .rst_i(rst), .load_code_i(vcode), .ierr_code_i(icode),
      .ilim_trip_i(ilim), .ramp_trip_i(ramp), .drive_en_i(en), .gate_o(gate)
   );

   function automatic int exp_per(int v);
      int p;
      if (v <= FLR) return MAXP;
      p = NOM + (KNEE - v) * SLOPE;
      return (p > MAXP) ? MAXP : p;
   endfunction

   function automatic int exp_wid(int c, int p);
      int t, m;
      t = (c * p) >> 8;
      if (t < MINON) t = MINON;
      m = (p * DUTY) >> 8;
      return (t > m) ? m : t;
   endfunction

   task automatic check_eq(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_rise();
      logic prev;
      int guard;
      prev = gate;
      guard = 0;
      forever begin
         @(negedge clk);
         guard++;
         if (!prev && gate) break;
         prev = gate;
         if (guard > 2000) begin
            check_eq("rise timeout", 0, 1);
            break;
         end
      end
   endtask

   // Call right at a rise sample; records n rise-to-rise periods and widths.
   task automatic measure(int n);
      for (int k = 0; k < n; k++) begin
         int p, w;
         logic prev;
         p = 0; w = 0;
         do begin
            p++;
            if (gate) w++;
            prev = gate;
            @(negedge clk);
         end while (!(!prev && gate) && p < 2000);
         per_a[k] = p;
         wid_a[k] = w;
      end
   endtask

   function automatic string wid_tag(int c, int p);
      int t;
      t = (c * p) >> 8;
      if (t < MINON) return "R8 min on-time";
      if (t > ((p * DUTY) >> 8)) return "R7 duty cap";
      return "R2 control width";
   endfunction

   initial begin
      int vlist[11];
      vlist = '{0, 8, 16, 17, 40, 64, 100, 127, 128, 200, 255};

      // R1: gate low during reset
      repeat (4) begin
         @(negedge clk);
         check_eq("R1 gate during reset", int'(gate), 0);
      end
      rst = 1'b0;

      // Load-code sweep with icode at full scale: period law and width
      foreach (vlist[j]) begin
         vcode = 8'(vlist[j]);
         wait_rise();
         measure(2);
         if (vlist[j] >= KNEE) begin
            total++;
            if (per_a[0] < NOM - DEV || per_a[0] > NOM + DEV) begin
               bad++;
               $display("FAIL R3 band: actual=%0d expected=%0d..%0d",
                        per_a[0], NOM - DEV, NOM + DEV);
            end
         end else if (vlist[j] <= FLR) begin
            check_eq("R6 floor period", per_a[0], MAXP);
         end else begin
            check_eq("R5 stretched period", per_a[0], exp_per(vlist[j]));
         end
         check_eq(wid_tag(vlist[j], per_a[0]), wid_a[0], exp_wid(vlist[j], per_a[0]));
      end

      // Error-code sweep at a fixed stretched period (load code 100 -> 96)
      vcode = 8'd100;
      for (int ic = 0; ic < 256; ic += 5) begin
         int c;
         icode = 8'(ic);
         c = (ic < 100) ? ic : 100;
         wait_rise();
         measure(1);
         check_eq("R5 period in error sweep", per_a[0], exp_per(100));
         check_eq(wid_tag(c, per_a[0]), wid_a[0], exp_wid(c, per_a[0]));
      end
      icode = 8'd255;

      // R4: dither at heavy load
      vcode = 8'd200;
      wait_rise();
      measure(18);
      begin
         int lo, hi;
         bit steps_ok;
         lo = 1 << 20; hi = 0; steps_ok = 1'b1;
         for (int k = 1; k < 18; k++) begin
            int d;
            d = per_a[k] - per_a[k-1];
            if (d != 1 && d != -1) steps_ok = 1'b0;
         end
         for (int k = 0; k < 18; k++) begin
            if (per_a[k] < lo) lo = per_a[k];
            if (per_a[k] > hi) hi = per_a[k];
            check_eq(wid_tag(200, per_a[k]), wid_a[k], exp_wid(200, per_a[k]));
         end
         check_eq("R4 unit steps", int'(steps_ok), 1);
         check_eq("R4 low edge", lo, NOM - DEV);
         check_eq("R4 high edge", hi, NOM + DEV);
      end

      // R10: current-limit held high -> only blanking holds the pulse
      ilim = 1'b1;
      wait_rise();
      measure(1);
      check_eq("R10 blanked ilim width", wid_a[0], BLANK + 1);
      ilim = 1'b0;

      // R9: current-limit raised at count 10
      wait_rise();
      repeat (10) @(negedge clk);
      ilim = 1'b1;
      begin
         int n;
         n = 0;
         while (gate && n < 100) begin n++; @(negedge clk); end
         check_eq("R9 ilim cut width", 10 + n, 11);
      end
      ilim = 1'b0;

      // R11: ramp flag held high and raised at count 10
      ramp = 1'b1;
      wait_rise();
      measure(1);
      check_eq("R11 held ramp width", wid_a[0], (BLANK + 1 > MINON) ? BLANK + 1 : MINON);
      ramp = 1'b0;
      wait_rise();
      repeat (10) @(negedge clk);
      ramp = 1'b1;
      begin
         int n;
         n = 0;
         while (gate && n < 100) begin n++; @(negedge clk); end
         check_eq("R11 ramp cut width", 10 + n, 11);
      end
      ramp = 1'b0;

      // R12: enable drop mid-pulse and re-raise mid-period (period 96, no dither)
      vcode = 8'd100;
      wait_rise();
      wait_rise();
      repeat (2) @(negedge clk);
      en = 1'b0;
      #1;
      check_eq("R12 immediate off", int'(gate), 0);
      repeat (8) @(negedge clk);
      en = 1'b1;
      #1;
      begin
         bit quiet;
         quiet = (gate == 1'b0);
         repeat (85) begin
            @(negedge clk);
            if (gate) quiet = 1'b0;
         end
         check_eq("R12 waits for period start", int'(quiet), 1);
         @(negedge clk);
         check_eq("R12 resumes at period start", int'(gate), 1);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=done", WATCHDOG);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule